// File: doc/BRIEF.md
# Programmable Wait-State Generator

This block stretches card accesses by driving an active-low bus wait signal for a programmed time. When any read or write strobe (memory output enable, memory write enable, I/O read, I/O write) falls while at least one of the two chip enables is low, the block pulls its wait output low. It holds it there for a number of clock periods taken from a fixed, roughly doubling table, then lets it go. The block runs from a 20 MHz clock, so one clock is 50 ns.

The duration is picked by a 3-bit code held in a host control byte. The two low bits of the code are bits 3:2 of that byte and the top bit is bit 7. A separate float input drops the output enable of the wait pin, so that the pin can share the tri-state control of the other card status outputs. The card strobes are asynchronous to the block clock and pass through a two-flop synchroniser before the block sees them.

Top module: `wait_state_gen`

## Requirements
- R1: After reset, with no access in progress, `waitN` is 1. `waitOe` is 1 whenever `floatOut` is 0.
- R2: The select code is {ctrlReg[7], ctrlReg[3], ctrlReg[2]}. The other bits of `ctrlReg` have no effect on the wait duration.
- R3: For select codes 1 to 7, `waitN` stays low for 1, 2, 4, 8, 16, 33 and 63 clocks, which is 50 ns to 3160 ns rounded to whole 50 ns clocks. It then returns to 1 even if the strobe is still low.
- R4: An access start is a falling edge of any of `oeN`, `weN`, `iordN` or `iowrN` while `ce1N` or `ce2N` is low. A strobe that falls while both chip enables are high leaves `waitN` at 1.
- R5: A strobe and chip enable driven low together between clock edges make `waitN` go low after the third following rising edge. This is two synchroniser stages plus one edge-detect register.
- R6: Select code 000 never drives `waitN` low.
- R7: If the qualified strobe goes away before the count expires, `waitN` returns to 1 after the third rising edge following the strobe's release.
- R8: While `waitN` is low, and while a strobe stays low after expiry, another strobe falling does not restart or extend the wait.
- R9: The select code is sampled when the access starts. Changing `ctrlReg` during a wait does not change that wait's length.
- R10: `floatOut` = 1 forces `waitOe` to 0 and does not change the timing of `waitN`.
- R11: Each of the four strobe types starts a wait, qualified by either chip enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 20 MHz block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oeN | input | 1 | Memory output enable, active low, asynchronous |
| weN | input | 1 | Memory write enable, active low, asynchronous |
| iordN | input | 1 | I/O read strobe, active low, asynchronous |
| iowrN | input | 1 | I/O write strobe, active low, asynchronous |
| ce1N | input | 1 | Chip enable 1, active low, asynchronous |
| ce2N | input | 1 | Chip enable 2, active low, asynchronous |
| ctrlReg | input | 8 | Host control byte; select code in bits 7, 3, 2 |
| floatOut | input | 1 | 1 floats the wait pin |
| waitN | output | 1 | Wait value, active low |
| waitOe | output | 1 | Output enable for the wait pin |

## Verification
The bench targets the boundaries of the duration table: code 000 must never assert wait, and the two rounded entries (33 and 63 clocks) must be exact. An off-by-one counter would show up as a wait one clock short or long on every code. It releases the strobe early and checks that the wait is dropped three edges later; a design missing the early release would hold the bus for the full count. It holds a strobe far past expiry and drops a second strobe during a wait; a design that retriggers on level instead of on an edge would assert wait again. It rewrites the select code mid-wait and sets unrelated control bits; a design that reads the code live, or decodes the wrong bit positions, would change the duration.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

  typedef struct packed {
    logic load;
    logic dec;
    logic clear;
  } cntCmd_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } wsgState_t;

  // Wait length in nanoseconds for each select code.
  function automatic int nsForCode(input logic [2:0] code);
    case (code)
      3'd0:    return 0;
      3'd1:    return 50;
      3'd2:    return 100;
      3'd3:    return 200;
      3'd4:    return 400;
      3'd5:    return 800;
      3'd6:    return 1650;
      default: return 3160;
    endcase
  endfunction

  // Rounded to whole clocks.
  function automatic int cyclesForCode(input logic [2:0] code, input int periodNs);
    return (nsForCode(code) + periodNs / 2) / periodNs;
  endfunction

  function automatic int maxCycles(input int periodNs);
    int m;
    m = 0;
    for (int c = 0; c < 8; c++) begin
      if (cyclesForCode(3'(c), periodNs) > m) m = cyclesForCode(3'(c), periodNs);
    end
    return m;
  endfunction

endpackage

// File: rtl/wsg_ctrl.sv
module wsg_ctrl
  import wsg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_LINES   = 6,
  parameter int CNT_W       = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] rawN,      // {ce2N, ce1N, iowrN, iordN, weN, oeN}
  input  logic                 zeroDur,
  input  logic                 cntOne,
  input  logic [CNT_W-1:0]     cntVal,
  output cntCmd_t              cmd,
  output logic                 waitN
);

  localparam int STROBES = NUM_LINES - 2;

  logic [NUM_LINES-1:0] syncedN;
  logic                 accessNow;
  logic                 accessPrev;
  logic                 startPulse;
  wsgState_t            state, stateNext;

  // Per-line synchroniser, reset to the inactive (high) level.
  genvar gl;
  generate
    for (gl = 0; gl < NUM_LINES; gl++) begin : g_sync
      logic [SYNC_STAGES-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[SYNC_STAGES-2:0], rawN[gl]};
      end
      assign syncedN[gl] = pipe[SYNC_STAGES-1];
    end
  endgenerate

  assign accessNow  = (~syncedN[NUM_LINES-1] | ~syncedN[NUM_LINES-2]) & (|(~syncedN[STROBES-1:0]));
  assign startPulse = accessNow & ~accessPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) accessPrev <= 1'b0;
    else        accessPrev <= accessNow;
  end

  always_comb begin
    stateNext = state;
    cmd       = '0;
    case (state)
      ST_IDLE: begin
        if (startPulse && !zeroDur) begin
          cmd.load  = 1'b1;
          stateNext = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!accessNow || cntOne) begin
          cmd.clear = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          cmd.dec = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign waitN = (state != ST_WAIT);

  // R6: a zero-length code never enters the wait state
  a_r6_zero_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && startPulse && zeroDur) |=> (state == ST_IDLE));

  // R7: losing the qualified strobe ends the wait on the next edge
  a_r7_early_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !accessNow) |=> (state == ST_IDLE));

  // R3: the counter in the datapath is live whenever a wait is held
  a_r3_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> (cntVal != '0));

  // R3: the last counted clock ends the wait
  a_r3_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && cntVal == CNT_W'(1)) |=> (state == ST_IDLE));

  // R8: a running wait with the strobe still present is not restarted
  a_r8_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && accessNow && !cntOne) |=> (state == ST_WAIT && cntVal == $past(cntVal) - CNT_W'(1)));

endmodule

// File: rtl/wsg_datapath.sv
module wsg_datapath
  import wsg_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 50,
  parameter int CNT_W         = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       selCode,
  input  cntCmd_t          cmd,
  output logic             zeroDur,
  output logic             cntOne,
  output logic [CNT_W-1:0] cntVal
);

  localparam int MAX_CYC = maxCycles(CLK_PERIOD_NS);

  logic [CNT_W-1:0] durLut [8];
  logic [CNT_W-1:0] cnt;

  genvar gc;
  generate
    for (gc = 0; gc < 8; gc++) begin : g_lut
      assign durLut[gc] = CNT_W'(cyclesForCode(3'(gc), CLK_PERIOD_NS));
    end
  endgenerate

  assign zeroDur = (durLut[selCode] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (cmd.load)  cnt <= durLut[selCode];
    else if (cmd.clear) cnt <= '0;
    else if (cmd.dec)   cnt <= cnt - CNT_W'(1);
  end

  assign cntOne = (cnt == CNT_W'(1));
  assign cntVal = cnt;

  // R8: without a load request the count never grows
  a_r8_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.load |=> (cnt <= $past(cnt)));

  // R3: the count never exceeds the longest table entry
  a_r3_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_CYC));

  // R9: after a load the count follows only the decrement path
  a_r9_code_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.dec && !cmd.load) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen
  import wsg_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 50,
  parameter int SYNC_STAGES   = 2,
  parameter int SEL_LO_POS    = 2,
  parameter int SEL_HI_POS    = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oeN,
  input  logic       weN,
  input  logic       iordN,
  input  logic       iowrN,
  input  logic       ce1N,
  input  logic       ce2N,
  input  logic [7:0] ctrlReg,
  input  logic       floatOut,
  output logic       waitN,
  output logic       waitOe
);

  localparam int CNT_W     = $clog2(maxCycles(CLK_PERIOD_NS) + 1);
  localparam int NUM_LINES = 6;

  logic [2:0]       selCode;
  logic             unusedCtrl;
  cntCmd_t          cmd;
  logic             zeroDur;
  logic             cntOne;
  logic [CNT_W-1:0] cntVal;

  assign selCode    = {ctrlReg[SEL_HI_POS], ctrlReg[SEL_LO_POS+1], ctrlReg[SEL_LO_POS]};
  assign unusedCtrl = ^{ctrlReg[6:4], ctrlReg[1:0]};

  wsg_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .NUM_LINES  (NUM_LINES),
    .CNT_W      (CNT_W)
  ) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .rawN   ({ce2N, ce1N, iowrN, iordN, weN, oeN}),
    .zeroDur(zeroDur),
    .cntOne (cntOne),
    .cntVal (cntVal),
    .cmd    (cmd),
    .waitN  (waitN)
  );

  wsg_datapath #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .CNT_W        (CNT_W)
  ) dp_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .selCode(selCode),
    .cmd    (cmd),
    .zeroDur(zeroDur),
    .cntOne (cntOne),
    .cntVal (cntVal)
  );

  assign waitOe = ~floatOut;

endmodule

// File: tb/wait_state_gen_tb.sv
module wait_state_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] strbN = 4'hF;   // {iowrN, iordN, weN, oeN}
  logic [1:0] ceN = 2'b11;    // {ce2N, ce1N}
  logic [7:0] ctrlReg = 8'h00;
  logic       floatOut = 1'b0;
  logic       waitN, waitOe;
  int         nChecks = 0;
  int         nFail = 0;

  always #10 clk = ~clk;

  wait_state_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .oeN(strbN[0]), .weN(strbN[1]), .iordN(strbN[2]), .iowrN(strbN[3]),
    .ce1N(ceN[0]), .ce2N(ceN[1]),
    .ctrlReg(ctrlReg), .floatOut(floatOut),
    .waitN(waitN), .waitOe(waitOe)
  );

  function automatic int expCycles(input int code);
    case (code)
      0: return 0;  1: return 1;  2: return 2;  3: return 4;
      4: return 8;  5: return 16; 6: return 33; default: return 63;
    endcase
  endfunction

  // Code bits at 7, 3, 2; junk fills every other bit.
  function automatic logic [7:0] mkCtrl(input int code, input bit junk);
    logic [7:0] v;
    v = junk ? 8'b0111_0011 : 8'h00;
    v[7] = code[2];
    v[3] = code[1];
    v[2] = code[0];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // ceSel: 0 = CE1, 1 = CE2, 2 = none
  task automatic runAccess(input int strb, input int ceSel, input int code, input int hold,
                           input int altAt, input int altCode, input int extraAt, input bit junk,
                           output int firstLow, output int lowCnt, output int lastLow);
    firstLow = -1; lowCnt = 0; lastLow = -1;
    ctrlReg = mkCtrl(code, junk);
    repeat (3) @(negedge clk);
    strbN[strb] = 1'b0;
    if (ceSel < 2) ceN[ceSel] = 1'b0;
    for (int i = 1; i <= hold + 6; i++) begin
      @(negedge clk);
      if (!waitN) begin
        if (firstLow < 0) firstLow = i;
        lowCnt++;
        lastLow = i;
      end
      if (i == altAt) ctrlReg = mkCtrl(altCode, junk);
      if (i == extraAt) strbN[(strb + 2) % 4] = 1'b0;
      if (i == hold) begin
        strbN = 4'hF;
        ceN = 2'b11;
      end
    end
  endtask

  task automatic testReset();
    check(waitN === 1'b1, "R1 waitN after reset", waitN, 1);
    check(waitOe === 1'b1, "R1 waitOe after reset", waitOe, 1);
  endtask

  task automatic testTable();
    int f, n, l;
    for (int c = 0; c < 8; c++) begin
      runAccess(0, 0, c, 75, -1, 0, -1, 1'b0, f, n, l);
      check(n == expCycles(c), $sformatf("R3 length code %0d", c), n, expCycles(c));
      if (c == 0) check(f == -1, "R6 code 000 never asserts", f, -1);
      else        check(f == 3, $sformatf("R5 latency code %0d", c), f, 3);
    end
  endtask

  task automatic testBitPositions();
    int f, n, l;
    runAccess(0, 0, 5, 30, -1, 0, -1, 1'b1, f, n, l);
    check(n == 16, "R2 junk bits ignored code 5", n, 16);
    runAccess(0, 0, 0, 20, -1, 0, -1, 1'b1, f, n, l);
    check(n == 0, "R2 R6 junk bits with code 000", n, 0);
    runAccess(0, 0, 4, 20, -1, 0, -1, 1'b0, f, n, l);
    check(n == 8, "R2 bit 7 alone selects code 4", n, 8);
  endtask

  task automatic testStrobeTypes();
    int f, n, l;
    runAccess(1, 1, 2, 12, -1, 0, -1, 1'b0, f, n, l);
    check(n == 2, "R11 write enable with CE2", n, 2);
    runAccess(2, 0, 2, 12, -1, 0, -1, 1'b0, f, n, l);
    check(n == 2, "R11 I/O read with CE1", n, 2);
    runAccess(3, 1, 3, 12, -1, 0, -1, 1'b0, f, n, l);
    check(n == 4, "R11 I/O write with CE2", n, 4);
    runAccess(0, 1, 1, 12, -1, 0, -1, 1'b0, f, n, l);
    check(n == 1, "R11 output enable with CE2", n, 1);
  endtask

  task automatic testNoChipEnable();
    int f, n, l;
    runAccess(2, 2, 5, 25, -1, 0, -1, 1'b0, f, n, l);
    check(n == 0, "R4 no chip enable, no wait", n, 0);
  endtask

  task automatic testEarlyRelease();
    int f, n, l;
    runAccess(0, 0, 7, 10, -1, 0, -1, 1'b0, f, n, l);
    check(l == 12, "R7 release three edges after strobe", l, 12);
    check(n == 10, "R7 low clocks before release", n, 10);
  endtask

  task automatic testNoRetrigger();
    int f, n, l;
    runAccess(0, 0, 4, 40, -1, 0, 20, 1'b0, f, n, l);
    check(n == 8, "R8 held strobe after expiry", n, 8);
    runAccess(3, 1, 5, 40, -1, 0, 6, 1'b0, f, n, l);
    check(n == 16, "R8 second strobe during wait", n, 16);
  endtask

  task automatic testCodeLatched();
    int f, n, l;
    runAccess(0, 0, 5, 30, 5, 1, -1, 1'b0, f, n, l);
    check(n == 16, "R9 code change mid-wait", n, 16);
  endtask

  task automatic testFloat();
    int f, n, l;
    @(negedge clk);
    floatOut = 1'b1;
    @(negedge clk);
    check(waitOe === 1'b0, "R10 float drops enable", waitOe, 0);
    runAccess(1, 0, 3, 15, -1, 0, -1, 1'b0, f, n, l);
    check(n == 4 && f == 3, "R10 timing unchanged while floated", n, 4);
    floatOut = 1'b0;
    @(negedge clk);
    check(waitOe === 1'b1, "R1 enable restored", waitOe, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testTable();
    testBitPositions();
    testStrobeTypes();
    testNoChipEnable();
    testEarlyRelease();
    testNoRetrigger();
    testCodeLatched();
    testFloat();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule